// File: doc/BRIEF.md
# Prescaled Mode-Switchable Down-Counter

This block is one programmable timer channel. It runs on the peripheral clock and moves one step only on the cycles where its prescaler, set by a control field, lets a count through. Software-side logic elsewhere decodes the bus and gives the channel a write strobe, a two-bit register select and 32 bits of data. The channel returns its control, reload and current count for readback. It also drives a raw event flag and a level interrupt.

The counter can be 16 or 32 bits wide. After zero it either wraps to all ones or reloads a programmed value. It can stop after one pass, or keep going. There are two ways to write the reload value. A direct load also sets the count. A background load changes only the value used at the next reload. The width can change while the counter runs. In 16-bit mode the upper halves of the count and of the reload value are held and read back unchanged.

Top module: `prescaled_downcounter`

## Requirements
- R1: Control bits are: [0] one-shot, [1] width (1 = 32-bit, 0 = 16-bit), [3:2] prescale code, [5] interrupt enable, [6] reload mode (1 = periodic, 0 = free-running), [7] run. Bit 4 is ignored and reads back as 0. Register select codes are 0 load, 1 background load, 2 control, 3 clear.
- R2: Prescale code 0 steps on every clock. Code 1 steps once per 16 clocks and code 2 once per 256 clocks; code 3 behaves like code 2. With code 1, the first step comes on the 16th rising edge after the edge that set run, and code 2 or 3 behave the same way with the 256th edge.
- R3: In 16-bit mode only count bits [15:0] change. Bits [31:16] of both the count and the reload value are kept and read back. After a switch to 32-bit mode, the full 32-bit count decrements.
- R4: A step from an effective count of zero wraps the active width to all ones in free-running mode, and reloads the active width from the reload value in periodic mode.
- R5: A load write sets the reload value and the full count on the next edge, and this write wins over a step in the same cycle. In free-running mode it does not change the wrap value.
- R6: A background-load write changes only the reload value. The count is not touched.
- R7: After reset, control reads 0x20, reload value 0, count 0xFFFFFFFF and the raw flag 0. The first step then goes from an effective 0xFFFF.
- R8: The raw flag sets on a step from an effective count of one to zero. Any write to select 3 clears it, and a set in the same cycle wins over the clear.
- R9: In one-shot mode the counter stops after the step that reaches zero. Any control write with bit 7 set restarts it, even when bit 7 was already set.
- R10: In periodic mode a load of zero holds the count at zero with no events. A nonzero load while running restarts a stopped one-shot counter.
- R11: While bit 7 is clear the count holds its value, and the prescaler phase is reset.
- R12: The interrupt output is a registered level equal to the raw flag AND the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 load, 1 background load, 2 control, 3 clear |
| wr_data | input | 32 | Write data |
| ctrl_rd | output | 8 | Control register readback |
| load_rd | output | 32 | Reload value readback |
| value_rd | output | 32 | Current count readback |
| raw_int | output | 1 | Raw event flag |
| irq | output | 1 | Masked interrupt level |

## Verification
The bench builds the channel with the default prescaler shifts of 4 and 8, which give the true 16 and 256 clock divisions. At these values the exact edge of the first prescaled step is cheap to reach, for code 1, code 2 and the aliased code 3. The same bench runs a short vector table covering the periodic, one-shot and background-load interplay. It then uses directed runs to cover the 16-bit upper-half retention across a width switch, a set and a clear landing on the same edge, and the zero-load stall.

// File: rtl/prescaled_downcounter.sv
module prescaled_downcounter #(
  parameter int MID_SHIFT  = 4,
  parameter int SLOW_SHIFT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [7:0]  ctrl_rd,
  output logic [31:0] load_rd,
  output logic [31:0] value_rd,
  output logic        raw_int,
  output logic        irq
);
  localparam int          HALF      = 16;
  localparam logic [7:0]  CTRL_MASK = 8'hEF;
  localparam logic [7:0]  CTRL_INIT = 8'h20;

  logic [7:0]            ctrl_q, ctrl_d;
  logic [31:0]           load_q, cnt_q, cnt_d, reload_v;
  logic                  raw_q, raw_d, irq_q, stop_q, stop_d;
  logic [SLOW_SHIFT-1:0] pre_q;
  logic                  phase_hit, tick, eff_zero, eff_one, hit;

  wire one_shot = ctrl_q[0];
  wire wide     = ctrl_q[1];
  wire periodic = ctrl_q[6];
  wire running  = ctrl_q[7];

  wire wr_load = wr_en && (wr_sel == 2'd0);
  wire wr_bg   = wr_en && (wr_sel == 2'd1);
  wire wr_ctrl = wr_en && (wr_sel == 2'd2);
  wire wr_clr  = wr_en && (wr_sel == 2'd3);

  always_comb begin
    case (ctrl_q[3:2])
      2'd0:    phase_hit = 1'b1;
      2'd1:    phase_hit = &pre_q[MID_SHIFT-1:0];
      default: phase_hit = &pre_q;
    endcase
  end

  assign tick     = running && !stop_q && phase_hit;
  assign eff_zero = wide ? (cnt_q == 32'd0) : (cnt_q[HALF-1:0] == '0);
  assign eff_one  = wide ? (cnt_q == 32'd1) : (cnt_q[HALF-1:0] == 16'd1);
  assign hit      = tick && eff_one;
  assign reload_v = periodic ? load_q : '1;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (eff_zero) begin
        if (wide) cnt_d = reload_v;
        else      cnt_d[HALF-1:0] = reload_v[HALF-1:0];
      end else begin
        if (wide) cnt_d = cnt_q - 32'd1;
        else      cnt_d[HALF-1:0] = cnt_q[HALF-1:0] - 16'd1;
      end
    end
    if (wr_load) cnt_d = wr_data;
  end

  always_comb begin
    stop_d = stop_q;
    if (hit && one_shot) stop_d = 1'b1;
    if (wr_ctrl && wr_data[7]) stop_d = 1'b0;
    else if (wr_load && periodic && running && (wr_data != 32'd0)) stop_d = 1'b0;
  end

  assign raw_d  = hit ? 1'b1 : (wr_clr ? 1'b0 : raw_q);
  assign ctrl_d = wr_ctrl ? (wr_data[7:0] & CTRL_MASK) : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
      load_q <= '0;
      cnt_q  <= '1;
      raw_q  <= 1'b0;
      irq_q  <= 1'b0;
      stop_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      raw_q  <= raw_d;
      irq_q  <= raw_d & ctrl_d[5];
      stop_q <= stop_d;
      pre_q  <= running ? pre_q + 1'b1 : '0;
      if (wr_load || wr_bg) load_q <= wr_data;
    end
  end

  assign ctrl_rd  = ctrl_q;
  assign load_rd  = load_q;
  assign value_rd = cnt_q;
  assign raw_int  = raw_q;
  assign irq      = irq_q;
endmodule

module prescaled_downcounter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic [7:0]  ctrl_rd,
  input logic [31:0] load_rd,
  input logic [31:0] value_rd,
  input logic        raw_int,
  input logic        irq
);
  assert_ignored_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[4] == 1'b0);

  assert_upper_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rd[1] && !(wr_en && wr_sel == 2'd0)) |=> $stable(value_rd[31:16]));

  assert_load_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (value_rd == $past(wr_data) && load_rd == $past(wr_data)));

  assert_bg_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && !ctrl_rd[7]) |=> $stable(value_rd));

  assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rd[7] && !(wr_en && wr_sel == 2'd0)) |=> $stable(value_rd));

  assert_irq_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (raw_int && ctrl_rd[5]));
endmodule

bind prescaled_downcounter prescaled_downcounter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ctrl_rd(ctrl_rd), .load_rd(load_rd), .value_rd(value_rd),
  .raw_int(raw_int), .irq(irq)
);

// File: tb/tb_prescaled_downcounter.sv
`timescale 1ns/1ps
module tb_prescaled_downcounter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  ctrl_rd;
  logic [31:0] load_rd, value_rd;
  logic        raw_int, irq;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  prescaled_downcounter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .load_rd(load_rd), .value_rd(value_rd),
    .raw_int(raw_int), .irq(irq)
  );

  localparam logic [1:0] S_LD = 2'd0, S_BG = 2'd1, S_CT = 2'd2, S_CL = 2'd3;

  // {select, data, extra edges, expected count, expected raw flag}
  localparam int NV = 12;
  localparam logic [74:0] VEC [NV] = '{
    {S_LD, 32'h0000_0100, 8'd0, 32'h0000_0100, 1'b0},
    {S_CT, 32'h0000_0062, 8'd3, 32'h0000_0100, 1'b0},
    {S_CT, 32'h0000_00E2, 8'd5, 32'h0000_00FB, 1'b0},
    {S_BG, 32'h0000_0003, 8'd0, 32'h0000_00FA, 1'b0},
    {S_LD, 32'h0000_0002, 8'd0, 32'h0000_0002, 1'b0},
    {S_CL, 32'h0000_0000, 8'd1, 32'h0000_0000, 1'b1},
    {S_CL, 32'h0000_0000, 8'd0, 32'h0000_0002, 1'b0},
    {S_CT, 32'h0000_00E3, 8'd3, 32'h0000_0000, 1'b1},
    {S_CL, 32'h0000_0000, 8'd4, 32'h0000_0000, 1'b0},
    {S_CT, 32'h0000_00E3, 8'd1, 32'h0000_0002, 1'b0},
    {S_BG, 32'h0000_0007, 8'd2, 32'h0000_0000, 1'b1},
    {S_CT, 32'h0000_00E2, 8'd1, 32'h0000_0007, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(1);
    chk("R7 ctrl", {24'd0, ctrl_rd}, 32'h20);
    chk("R7 load", load_rd, 32'h0);
    chk("R7 value", value_rd, 32'hFFFF_FFFF);
    chk("R7 raw", {31'd0, raw_int}, 32'd0);
    chk("R12 irq reset", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    @(negedge clk);
    do_reset();

    // Table: R4 periodic reload, R5, R6, R8, R9 one-shot restart
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][74:73], VEC[i][72:41]);
      edges(int'(VEC[i][40:33]));
      chk($sformatf("R4/R5/R6/R8/R9 row%0d value", i), value_rd, VEC[i][32:1]);
      chk($sformatf("R8/R9 row%0d raw", i), {31'd0, raw_int}, {31'd0, VEC[i][0]});
    end

    do_reset();

    // R1 ignored control bit
    wr(S_CT, 32'hFFFF_FF10);
    chk("R1 ignored bits", {24'd0, ctrl_rd}, 32'h0);

    // R7 first step from 0xFFFF, R4 free-running wrap, R5 wrap unaffected
    wr(S_CT, 32'h0000_00A0);
    edges(3);
    chk("R7 first steps", value_rd, 32'hFFFF_FFFC);
    wr(S_LD, 32'h1234_0001);
    edges(1);
    chk("R8 zero event value", value_rd, 32'h1234_0000);
    chk("R8 raw set", {31'd0, raw_int}, 32'd1);
    chk("R12 irq set", {31'd0, irq}, 32'd1);
    edges(1);
    chk("R4 free wrap", value_rd, 32'h1234_FFFF);
    chk("R5 load kept", load_rd, 32'h1234_0001);

    // R8/R12 masking and clear
    wr(S_CT, 32'h0000_0080);
    chk("R8 raw unmasked", {31'd0, raw_int}, 32'd1);
    chk("R12 irq masked", {31'd0, irq}, 32'd0);
    wr(S_CL, 32'h0);
    chk("R8 clear", {31'd0, raw_int}, 32'd0);

    // R11 freeze
    wr(S_CT, 32'h0000_0000);
    hold = value_rd;
    edges(10);
    chk("R11 frozen", value_rd, hold);

    // R2 prescale code 1
    wr(S_LD, 32'h0000_1000);
    wr(S_CT, 32'h0000_0084);
    edges(15);
    chk("R2 div16 before", value_rd, 32'h0000_1000);
    edges(1);
    chk("R2 div16 step", value_rd, 32'h0000_0FFF);
    edges(16);
    chk("R2 div16 second", value_rd, 32'h0000_0FFE);

    // R2 prescale code 2 and 3, R11 phase reset
    wr(S_CT, 32'h0000_0000);
    wr(S_LD, 32'h0000_0050);
    wr(S_CT, 32'h0000_0088);
    edges(255);
    chk("R2 div256 before", value_rd, 32'h0000_0050);
    edges(1);
    chk("R2 div256 step", value_rd, 32'h0000_004F);
    wr(S_CT, 32'h0000_0000);
    wr(S_LD, 32'h0000_0050);
    wr(S_CT, 32'h0000_008C);
    edges(255);
    chk("R2 code3 before", value_rd, 32'h0000_0050);
    edges(1);
    chk("R2 code3 step", value_rd, 32'h0000_004F);

    // R3 width switch keeps upper half
    wr(S_CT, 32'h0000_0000);
    wr(S_LD, 32'hABCD_0003);
    wr(S_CT, 32'h0000_0080);
    edges(3);
    chk("R3 low half zero", value_rd, 32'hABCD_0000);
    edges(1);
    chk("R3 wrap keeps upper", value_rd, 32'hABCD_FFFF);
    chk("R3 load upper", load_rd, 32'hABCD_0003);
    wr(S_CT, 32'h0000_0082);
    chk("R3 last 16-bit step", value_rd, 32'hABCD_FFFE);
    edges(1);
    chk("R3 32-bit step", value_rd, 32'hABCD_FFFD);

    // R8 set wins over clear
    wr(S_CT, 32'h0000_00A0);
    wr(S_CL, 32'h0);
    wr(S_LD, 32'h0000_0002);
    edges(1);
    wr(S_CL, 32'h0);
    chk("R8 set over clear value", value_rd, 32'h0);
    chk("R8 set over clear raw", {31'd0, raw_int}, 32'd1);

    // R10 periodic zero load stalls
    wr(S_CL, 32'h0);
    wr(S_CT, 32'h0000_00E2);
    wr(S_LD, 32'h0);
    edges(5);
    chk("R10 zero load value", value_rd, 32'h0);
    chk("R10 zero load raw", {31'd0, raw_int}, 32'd0);

    // R9 one-shot stop, R10 nonzero load restart
    wr(S_CT, 32'h0000_00E3);
    wr(S_LD, 32'h0000_0002);
    edges(5);
    chk("R9 one-shot stopped", value_rd, 32'h0);
    chk("R9 one-shot raw", {31'd0, raw_int}, 32'd1);
    wr(S_LD, 32'h0000_0005);
    chk("R10 restart load", value_rd, 32'h5);
    edges(1);
    chk("R10 restarted", value_rd, 32'h4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule